// File: doc/BRIEF.md
# Receive Polarity Detector and Corrector

This block finds and undoes a swapped receive pair on a 10 Mb/s twisted-pair link. The receive front end reports four single-cycle event strobes: a link pulse of normal shape, a link pulse of inverted shape, an end-of-frame marker of normal shape, and an end-of-frame marker of inverted shape. The block keeps two independent run counters, one for each event type. A run of inverted events of one type with no interruption sets a sticky "inverted" state. While that state is set, the serial receive bit is passed through an inverter.

A quiet line returns the block to normal polarity. A millisecond tick drives an idle timer. When the timer reaches its limit with no event strobes and no receive data activity, the inverted state is cleared, along with both run counters. The limit is a parameter, meant to sit between 96 and 128 ms, with a default of 112 ms. Downstream logic uses the corrected bit and the status flag.

Top module: `polfix_top`

## Requirements
- R1: After reset `pol_inv_o` is 0, both run counters are at zero, and the idle count is zero.
- R2: The inverted state is set on the clock edge that samples the LP_RUN-th (default 8) consecutive inverted link-pulse strobe. It is not set after LP_RUN-1 of them.
- R3: The inverted state is set on the clock edge that samples the EOF_RUN-th (default 4) consecutive inverted end-of-frame strobe. It is not set after EOF_RUN-1 of them.
- R4: A normal-polarity strobe of one type resets that type's run counter to zero. It leaves the other type's counter unchanged.
- R5: The two counters never add up. Inverted link pulses and inverted end-of-frame markers in any mix set the state only when one type alone reaches its own threshold.
- R6: `rx_bit_o` equals `rx_bit_i` when `pol_inv_o` is 0. It equals the inverse of `rx_bit_i` when `pol_inv_o` is 1. There is no register delay between them.
- R7: If TIMEOUT_MS ticks of `ms_tick_i` are sampled with no activity in between, then on the edge that samples the last of those ticks `pol_inv_o` goes to 0. Both run counters return to zero on the same edge.
- R8: Activity means any of the four event strobes, or `rx_active_i`, being high in a cycle. Activity restarts the idle count from zero, and a tick sampled in the same cycle as activity does not count.
- R9: A normal and an inverted strobe of the same type in the same cycle are treated as a normal strobe: that type's counter goes to zero.
- R10: When a counter reaches its threshold, that counter restarts from zero. The inverted state stays set, and only the idle timeout clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| lp_norm_i | input | 1 | Normal-polarity link pulse seen |
| lp_inv_i | input | 1 | Inverted link pulse seen |
| eof_norm_i | input | 1 | Normal-polarity end-of-frame marker seen |
| eof_inv_i | input | 1 | Inverted end-of-frame marker seen |
| rx_active_i | input | 1 | Receive data present this cycle |
| rx_bit_i | input | 1 | Raw serial receive bit |
| rx_bit_o | output | 1 | Polarity-corrected receive bit |
| pol_inv_o | output | 1 | Inverted-polarity state |

## Verification
The bench keeps the default run thresholds of 8 link pulses and 4 end-of-frame markers. It overrides TIMEOUT_MS to 96, the shortest timeout allowed. It raises the millisecond tick every other clock, so each timeout fits in a few hundred cycles. This lets the bench check both edges of each threshold: one event short and exactly on the threshold, 95 and 96 ticks. It also checks a timer restart by data activity only a few ticks before expiry, and a counter reset by the timeout.

// File: rtl/polfix_pkg.sv
package polfix_pkg;
  // one event class as reported by the receive front end
  typedef struct packed {
    logic norm;
    logic inv;
  } evt_t;

  localparam int unsigned NUM_EVT = 2;  // link pulse, end-of-frame
  localparam int unsigned EVT_LP  = 0;
  localparam int unsigned EVT_EOF = 1;
endpackage

// File: rtl/polfix_run_cnt.sv
module polfix_run_cnt
  import polfix_pkg::*;
#(
  parameter int unsigned THRESH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  evt_t ev_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q;

  // a normal strobe dominates an inverted one in the same cycle
  assign hit_o = ev_i.inv && !ev_i.norm && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (ev_i.norm)   cnt_q <= '0;
    else if (ev_i.inv)    cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
  end

  p_cnt_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(THRESH));
  p_norm_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.norm |=> cnt_q == '0);
  p_hit_restarts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cnt_q == '0);
endmodule

// File: rtl/polfix_idle_timer.sv
module polfix_idle_timer #(
  parameter int unsigned LIMIT = 112
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic act_i,
  output logic expire_o
);
  localparam int unsigned IW = $clog2(LIMIT + 1);
  localparam logic [IW-1:0] LAST = IW'(LIMIT - 1);

  logic [IW-1:0] idle_q;

  assign expire_o = tick_i && !act_i && (idle_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idle_q <= '0;
    else if (act_i)    idle_q <= '0;
    else if (tick_i)   idle_q <= expire_o ? '0 : idle_q + 1'b1;
  end

  p_idle_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q < IW'(LIMIT));
  p_act_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> idle_q == '0);
  p_quiet_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i && !tick_i) |=> $stable(idle_q));
endmodule

// File: rtl/polfix_top.sv
module polfix_top
  import polfix_pkg::*;
#(
  parameter int unsigned LP_RUN     = 8,
  parameter int unsigned EOF_RUN    = 4,
  parameter int unsigned TIMEOUT_MS = 112  // keep within 96..128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ms_tick_i,
  input  logic lp_norm_i,
  input  logic lp_inv_i,
  input  logic eof_norm_i,
  input  logic eof_inv_i,
  input  logic rx_active_i,
  input  logic rx_bit_i,
  output logic rx_bit_o,
  output logic pol_inv_o
);
  evt_t [NUM_EVT-1:0] evt;
  logic [NUM_EVT-1:0] hit;
  logic               expire;
  logic               activity;
  logic               pol_inv_q;

  assign evt[EVT_LP]  = '{norm: lp_norm_i,  inv: lp_inv_i};
  assign evt[EVT_EOF] = '{norm: eof_norm_i, inv: eof_inv_i};

  assign activity = lp_norm_i | lp_inv_i | eof_norm_i | eof_inv_i | rx_active_i;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_run
    localparam int unsigned TH = (k == EVT_LP) ? LP_RUN : EOF_RUN;
    polfix_run_cnt #(.THRESH(TH)) i_run (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (expire),
      .ev_i   (evt[k]),
      .hit_o  (hit[k])
    );
  end

  polfix_idle_timer #(.LIMIT(TIMEOUT_MS)) i_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (ms_tick_i),
    .act_i    (activity),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pol_inv_q <= 1'b0;
    else if (expire) pol_inv_q <= 1'b0;
    else if (|hit)   pol_inv_q <= 1'b1;
  end

  assign pol_inv_o = pol_inv_q;
  assign rx_bit_o  = rx_bit_i ^ pol_inv_q;

  p_set_on_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit) |=> pol_inv_o);
  p_clear_on_timeout_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> !pol_inv_o);
  p_hold_otherwise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!expire && !(|hit)) |=> $stable(pol_inv_o));
  p_no_hit_while_expire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |-> !(|hit));
endmodule

// File: tb/test_polfix_top.sv
module test_polfix_top;
  localparam int CLK_PERIOD = 10;
  localparam int LP_RUN  = 8;
  localparam int EOF_RUN = 4;
  localparam int TMO     = 96;

  logic clk = 0, rst_n = 0;
  logic tick = 0, lpn = 0, lpi = 0, eofn = 0, eofi = 0, act = 0, bit_in = 0;
  logic bit_out, pol;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  int m_lp = 0, m_eof = 0, m_idle = 0;
  bit m_inv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  polfix_top #(.LP_RUN(LP_RUN), .EOF_RUN(EOF_RUN), .TIMEOUT_MS(TMO)) i_polfix_top (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(tick),
    .lp_norm_i(lpn), .lp_inv_i(lpi), .eof_norm_i(eofn), .eof_inv_i(eofi),
    .rx_active_i(act), .rx_bit_i(bit_in), .rx_bit_o(bit_out), .pol_inv_o(pol)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      bit any_act, lp_hit, eof_hit, exp;
      any_act = lpn | lpi | eofn | eofi | act;
      lp_hit  = lpi && !lpn && (m_lp == LP_RUN - 1);
      eof_hit = eofi && !eofn && (m_eof == EOF_RUN - 1);
      exp     = tick && !any_act && (m_idle == TMO - 1);
      if (exp)       m_lp = 0;
      else if (lpn)  m_lp = 0;
      else if (lpi)  m_lp = lp_hit ? 0 : m_lp + 1;
      if (exp)       m_eof = 0;
      else if (eofn) m_eof = 0;
      else if (eofi) m_eof = eof_hit ? 0 : m_eof + 1;
      if (any_act)   m_idle = 0;
      else if (tick) m_idle = exp ? 0 : m_idle + 1;
      if (exp)                    m_inv = 0;
      else if (lp_hit || eof_hit) m_inv = 1;
    end
  end

  task automatic chk(string req, logic act_v, logic exp_v, string what);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act_v, exp_v);
    end
  endtask

  // per-cycle comparison against the model (R6 on every cycle)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, pol, m_inv, "pol_inv_o");
      chk("R6", bit_out, bit_in ^ m_inv, "rx_bit_o");
    end
  end

  task automatic cyc(bit ln, bit li, bit en, bit ei, bit a, bit t, bit b);
    @(negedge clk); #1;
    lpn = ln; lpi = li; eofn = en; eofi = ei; act = a; tick = t; bit_in = b;
  endtask

  task automatic idle_ticks(int n);
    for (int i = 0; i < n; i++) begin
      cyc(0,0,0,0,0,1,i[0]);
      cyc(0,0,0,0,0,0,~i[0]);
    end
  endtask

  task automatic lp_inv_n(int n);
    for (int i = 0; i < n; i++) begin
      cyc(0,1,0,0,0,0,1); cyc(0,0,0,0,0,0,0);
    end
  endtask

  task automatic eof_inv_n(int n);
    for (int i = 0; i < n; i++) begin
      cyc(0,0,0,1,0,0,0); cyc(0,0,0,0,0,0,1);
    end
  endtask

  task automatic settle;
    cyc(0,0,0,0,0,0,0); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*500000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", pol, 1'b0, "reset pol_inv_o");
    chk("R1", bit_out, bit_in, "reset rx_bit_o");
    rst_n = 1;

    cur_req = "R2";
    lp_inv_n(LP_RUN - 1); settle;
    chk("R2", pol, 1'b0, "after 7 inverted link pulses");
    lp_inv_n(1); settle;
    chk("R2", pol, 1'b1, "after 8 inverted link pulses");

    cur_req = "R6";
    cyc(0,0,0,0,0,0,1); @(negedge clk); chk("R6", bit_out, 1'b0, "inverted 1");
    cyc(0,0,0,0,0,0,0); @(negedge clk); chk("R6", bit_out, 1'b1, "inverted 0");

    cur_req = "R7";
    idle_ticks(TMO - 1); settle;
    chk("R7", pol, 1'b1, "after 95 idle ticks");
    idle_ticks(1); settle;
    chk("R7", pol, 1'b0, "after 96 idle ticks");
    cyc(0,0,0,0,0,0,1); @(negedge clk); chk("R6", bit_out, 1'b1, "normal passthrough");

    cur_req = "R4";
    eof_inv_n(EOF_RUN - 1);
    cyc(0,0,1,0,0,0,0);
    eof_inv_n(EOF_RUN - 1); settle;
    chk("R4", pol, 1'b0, "normal eof broke the run");
    cur_req = "R3";
    eof_inv_n(1); settle;
    chk("R3", pol, 1'b1, "after 4 inverted eof");

    cur_req = "R8";
    idle_ticks(TMO - 4);
    cyc(0,0,0,0,1,1,0);   // data activity with a tick: tick ignored
    idle_ticks(TMO - 1); settle;
    chk("R8", pol, 1'b1, "data activity restarted idle timer");
    cur_req = "R7";
    idle_ticks(1); settle;
    chk("R7", pol, 1'b0, "timeout after restart");

    cur_req = "R5";
    lp_inv_n(LP_RUN - 1);
    eof_inv_n(EOF_RUN - 1); settle;
    chk("R5", pol, 1'b0, "7 lp + 3 eof do not combine");
    cur_req = "R4";
    cyc(0,0,1,0,0,0,0); settle;   // clears eof only
    lp_inv_n(1); settle;
    chk("R4", pol, 1'b1, "lp run survived normal eof");

    cur_req = "R10";
    lp_inv_n(LP_RUN - 1); settle;
    chk("R10", pol, 1'b1, "state held after counter restart");
    idle_ticks(TMO); settle;
    chk("R7", pol, 1'b0, "timeout cleared state");
    lp_inv_n(1); settle;
    chk("R10", pol, 1'b0, "timeout zeroed lp counter");

    cur_req = "R9";
    lp_inv_n(LP_RUN - 2);
    cyc(1,1,0,0,0,0,0);
    lp_inv_n(LP_RUN - 1); settle;
    chk("R9", pol, 1'b0, "simultaneous strobes cleared run");
    lp_inv_n(1); settle;
    chk("R9", pol, 1'b1, "run completes after clear");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule